// File: doc/BRIEF.md
# Masked Interrupt Priority Vector Controller

This block gathers interrupt requests from sixteen regular sources and, when an enhanced mode is switched on, from thirty-two added level requests. Every request is caught in a pending register. A software-written mask register then gates each pending bit. From the bits that are both pending and unmasked, a fixed priority encoder picks a single winner. The winner's number, times four, is placed in the top byte of a read-only vector register. A single interrupt line tells the core that at least one enabled request is waiting.

Regular sources are numbered 0 to 15. Enhanced level j becomes source 16+j. A lower number always wins. Software reads the vector register and branches through a table at offset number×8. It then clears the pending bit by writing 1 to that bit. A vector code of 0x00 with the interrupt line low means that nothing is waiting.

The register port is a plain 3-bit address with a write strobe and a combinational read. The map is as follows:
- 0: pending 1, sources 0..15
- 1: mask 1
- 2: pending 2, levels 0..15
- 3: mask 2
- 4: pending 3, levels 16..31
- 5: mask 3
- 6: vector, read only
- 7: control, bit 0 enables the enhanced mode

Top module: `irq_vector_ctrl`

## Requirements
- R1: A request sets its bit in the pending register on the next clock edge, and the bit stays set after the line drops. A level-type regular source (a 1 in parameter LVL_SRC, default bits 7..0) sets its bit while it is high. An edge-type source (bits 15..8) sets its bit on a 0-to-1 change.
- R2: Writing 1 to a bit of a pending register (address 0, 2 or 4) clears that bit. A level-type bit whose line is still high is not cleared. A new set in the same cycle wins over the clear.
- R3: A pending bit whose mask bit is 0 still reads as 1 in its pending register. It does not raise irq_out and does not take part in arbitration. Mask bits are 1 = enabled, and they reset to 0.
- R4: Among the bits that are pending and unmasked, the lowest source number wins. Enhanced level j is source 16+j, so every regular source outranks every enhanced level.
- R5: The vector register (address 6) holds the winner's number × 4 in bits 31..24, and every other bit is 0. branch_ofs carries the number × 8. Both update on the clock edge after the pending or mask change.
- R6: When no pending bit is unmasked, the vector code reads 0x00, branch_ofs is 0 and irq_out is 0.
- R7: When control bit 0 is 1, req_lvl[15:0] sets bits of pending 2 and req_lvl[31:16] sets bits of pending 3. These bits are level-type, and masks 2 and 3 gate them.
- R8: While control bit 0 is 0, pending 2 and pending 3 are held at zero from the next edge on. They take no part in arbitration.
- R9: irq_out is the OR of all pending-and-unmasked bits. It rises in the same cycle as the pending bit, which is one cycle before the vector updates.
- R10: After reset, all pending, mask, vector and control state reads as 0, and irq_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_reg | input | 16 | Regular source requests, bit n is source n |
| req_lvl | input | 32 | Enhanced level requests, bit j is source 16+j |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| irq_out | output | 1 | Interrupt request to the core |
| branch_ofs | output | 16 | Branch-table offset of the current winner |

## Verification
The embedded properties check several rules on every cycle. A fully masked controller never drives irq_out. A level-type input that is high is always caught in its pending bit. The added pending registers stay empty while the enhanced mode is off. An enabled regular request always yields a code below 0x40. A cycle-level reference model in the bench covers the rest: the exact priority order across all 48 sources, the one-cycle lag between a pending change and the vector, the clear-by-write-one rules for edge-type and level-type bits, and what happens when the enhanced mode is switched on and off.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NREG = 16,
  parameter int NLVL = 32,
  parameter logic [15:0] LVL_SRC = 16'h00FF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] req_reg,
  input  logic [31:0] req_lvl,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq_out,
  output logic [15:0] branch_ofs
);
  localparam int HALF = NLVL / 2;
  localparam int NSRC = NREG + NLVL;
  localparam int IW   = $clog2(NSRC);

  logic [NREG-1:0] pend1, mask1, req_d;
  logic [HALF-1:0] pend2, pend3, mask2, mask3;
  logic            enh;
  logic [7:0]      code_q, code_n;
  logic [NSRC-1:0] act;
  logic [IW-1:0]   win;

  wire wr_p1 = wr_en && addr == 3'd0;
  wire wr_p2 = wr_en && addr == 3'd2;
  wire wr_p3 = wr_en && addr == 3'd4;

  wire [NREG-1:0] lvl_hi = req_reg & LVL_SRC;
  wire [NREG-1:0] set1 = lvl_hi | (req_reg & ~req_d & ~LVL_SRC);
  wire [NREG-1:0] clr1 = (wr_p1 ? wdata[NREG-1:0] : '0) & ~lvl_hi;
  wire [HALF-1:0] clr2 = (wr_p2 ? wdata[HALF-1:0] : '0) & ~req_lvl[HALF-1:0];
  wire [HALF-1:0] clr3 = (wr_p3 ? wdata[HALF-1:0] : '0) & ~req_lvl[NLVL-1:HALF];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend1 <= '0; pend2 <= '0; pend3 <= '0;
      mask1 <= '0; mask2 <= '0; mask3 <= '0;
      req_d <= '0; enh <= 1'b0; code_q <= '0;
    end else begin
      req_d  <= req_reg;
      pend1  <= (pend1 & ~clr1) | set1;
      pend2  <= enh ? ((pend2 & ~clr2) | req_lvl[HALF-1:0])    : '0;
      pend3  <= enh ? ((pend3 & ~clr3) | req_lvl[NLVL-1:HALF]) : '0;
      code_q <= code_n;
      if (wr_en && addr == 3'd1) mask1 <= wdata[NREG-1:0];
      if (wr_en && addr == 3'd3) mask2 <= wdata[HALF-1:0];
      if (wr_en && addr == 3'd5) mask3 <= wdata[HALF-1:0];
      if (wr_en && addr == 3'd7) enh   <= wdata[0];
    end
  end

  assign act = {pend3 & mask3, pend2 & mask2, pend1 & mask1};

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (act[i]) win = IW'(i);
    code_n = (|act) ? 8'(win) << 2 : 8'h00;
  end

  assign irq_out    = |act;
  assign branch_ofs = {7'b0, code_q, 1'b0};

  always_comb begin
    case (addr)
      3'd0:    rdata = 32'(pend1);
      3'd1:    rdata = 32'(mask1);
      3'd2:    rdata = 32'(pend2);
      3'd3:    rdata = 32'(mask2);
      3'd4:    rdata = 32'(pend3);
      3'd5:    rdata = 32'(mask3);
      3'd6:    rdata = {code_q, 24'h0};
      default: rdata = {31'h0, enh};
    endcase
  end

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (mask1 == '0 && mask2 == '0 && mask3 == '0) |-> !irq_out); // R3
  AST_LEVEL_CAUGHT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend1 & $past(lvl_hi)) == $past(lvl_hi))); // R1
  AST_ENH_OFF_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !enh |=> (pend2 == '0 && pend3 == '0)); // R8
  AST_REGULAR_FIRST: assert property (@(posedge clk) disable iff (rst)
    |(pend1 & mask1) |=> code_q < 8'h40); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irq_out |=> code_q == 8'h00); // R6
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] req_reg = '0;
  logic [31:0] req_lvl = '0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out;
  logic [15:0] branch_ofs;
  int total = 0, bad = 0;
  bit done = 0;
  localparam logic [15:0] LVL = 16'h00FF;

  always #5 clk = ~clk;

  irq_vector_ctrl u0 (.clk, .rst, .req_reg, .req_lvl, .addr, .wr_en, .wdata,
                      .rdata, .irq_out, .branch_ofs);

  bit mp[48], mm[48], mreq_d[16], men;
  int mvec;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 48; i++) begin mp[i] = 0; mm[i] = 0; end
      for (int i = 0; i < 16; i++) mreq_d[i] = 0;
      men = 0; mvec = 0;
    end else begin
      int w; w = -1;
      for (int i = 0; i < 48; i++) if (mp[i] && mm[i] && w < 0) w = i;
      for (int i = 0; i < 16; i++) begin
        bit clr; clr = wr_en && addr == 0 && wdata[i];
        if (LVL[i]) begin
          if (req_reg[i]) mp[i] = 1; else if (clr) mp[i] = 0;
        end else begin
          if (req_reg[i] && !mreq_d[i]) mp[i] = 1; else if (clr) mp[i] = 0;
        end
        mreq_d[i] = req_reg[i];
      end
      for (int k = 0; k < 32; k++) begin
        bit clr;
        clr = wr_en && ((k < 16 && addr == 2 && wdata[k]) || (k >= 16 && addr == 4 && wdata[k-16]));
        if (!men) mp[16+k] = 0;
        else if (req_lvl[k]) mp[16+k] = 1;
        else if (clr) mp[16+k] = 0;
      end
      if (wr_en) begin
        for (int i = 0; i < 16; i++) begin
          if (addr == 1) mm[i] = wdata[i];
          if (addr == 3) mm[16+i] = wdata[i];
          if (addr == 5) mm[32+i] = wdata[i];
        end
        if (addr == 7) men = wdata[0];
      end
      mvec = (w < 0) ? 0 : w * 4;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    bit any; any = 0;
    for (int i = 0; i < 48; i++) any |= mp[i] & mm[i];
    chk("R9 irq_out model", 32'(irq_out), 32'(any));
    chk("R5 branch_ofs model", 32'(branch_ofs), 32'(mvec * 2));
  end

  task automatic tick(); @(posedge clk); @(negedge clk); endtask
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1; tick(); wr_en = 0;
  endtask
  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr = a; #1; chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    rd(0, 0, "R10 pend1 reset"); rd(1, 0, "R10 mask1 reset");
    rd(6, 0, "R10 vector reset"); rd(7, 0, "R10 ctrl reset");
    chk("R10 irq reset", 32'(irq_out), 0);
    wr(1, 32'hFFFF);
    req_reg[9] = 1; tick(); req_reg[9] = 0;
    rd(0, 32'h200, "R1 edge source latched");
    chk("R9 irq same cycle", 32'(irq_out), 1);
    rd(6, 0, "R5 vector lags one cycle");
    tick();
    rd(0, 32'h200, "R1 stays after line drops");
    rd(6, 32'h2400_0000, "R5 code source 9");
    chk("R5 offset source 9", 32'(branch_ofs), 32'h48);
    req_reg[3] = 1; tick(); tick();
    rd(6, 32'h0C00_0000, "R4 source 3 beats 9");
    wr(0, 32'h8); tick();
    rd(0, 32'h208, "R2 level bit kept while high");
    req_reg[3] = 0; wr(0, 32'h8);
    rd(0, 32'h200, "R2 level bit cleared after drop");
    req_reg[10] = 1; tick();
    wr(0, 32'h400);
    rd(0, 32'h200, "R2 edge bit cleared while line high");
    req_reg[10] = 0;
    wr(0, 32'h200); tick();
    rd(6, 0, "R6 code zero when idle");
    chk("R6 irq low when idle", 32'(irq_out), 0);
    wr(1, 32'h0);
    req_reg[12] = 1; tick(); req_reg[12] = 0; tick();
    rd(0, 32'h1000, "R3 masked bit still pending");
    chk("R3 masked no irq", 32'(irq_out), 0);
    rd(6, 0, "R3 masked no vector");
    req_lvl = 32'h0010_0000; tick();
    rd(4, 0, "R8 pend3 held zero when off");
    wr(5, 32'hFFFF); wr(3, 32'hFFFF);
    wr(7, 1); tick();
    rd(4, 32'h10, "R7 level 20 in pend3");
    tick();
    rd(6, 32'h9000_0000, "R7 code source 36");
    chk("R7 offset source 36", 32'(branch_ofs), 32'h120);
    req_lvl = 32'h0000_0003; tick(); tick();
    rd(2, 32'h3, "R7 levels in pend2");
    rd(6, 32'h4000_0000, "R4 lowest enhanced level wins");
    wr(1, 32'h1000); tick();
    rd(6, 32'h3000_0000, "R4 regular outranks enhanced");
    req_lvl = 0;
    wr(7, 0); tick();
    rd(2, 0, "R8 pend2 cleared when off");
    rd(4, 0, "R8 pend3 cleared when off");
    wr(6, 32'hFFFF_FFFF);
    rd(6, 32'h3000_0000, "R5 vector read only");
    wr(0, 32'h1000); tick();
    rd(6, 0, "R6 all clear");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule